// File: doc/BRIEF.md
# Oscillator Failure Monitor with Backup Clock Switchover

This block watches an external oscillator with a free-running backup clock. A counter in the backup clock domain measures how long the external input has gone without a level change. If that time becomes too long, the block treats the oscillator as dead. It then moves the system clock onto the backup clock for good and raises an interrupt request. Only a hardware reset brings the external clock back.

A 3-bit mode strap is captured while reset is held. It chooses how the external source reaches the clock output: divided by two, passed straight through, or handed on unchanged as the reference for a frequency multiplier. The multiplier itself lives outside this block. A disable input, driven from a bit of the system configuration register, turns monitoring off and powers down the backup oscillator. The changeover between clock sources uses two gate enables, each registered in its own clock domain, so the backup gate opens only after the external gate is seen closed.

Top module: `osc_failover_top`

## Requirements
- R1: While `rst_n` is low, `mode_strap` is captured and decoded onto `clk_mode` as follows: 3'b001 gives 1 (external clock halved), 3'b011 gives 2 (external clock direct), and every other code gives 0 (multiplier reference, external clock passed through). Changes on `mode_strap` after reset have no effect.
- R2: In halved mode, `clk_out` has half the frequency of `ext_clk` while no failure has occurred.
- R3: Rising and falling edges of `ext_clk` both restart the timeout. When successive `ext_clk` transitions are spaced 16 or fewer `bkp_clk` cycles apart, no failure is ever declared.
- R4: When 17 or more `bkp_clk` cycles pass without an `ext_clk` transition while monitoring is on, a failure is declared. After that, `use_backup` reads 1 and `clk_out` toggles at the `bkp_clk` rate.
- R5: `irq_flag` goes to 1 when a failure is declared. It stays at 1 until a one on `irq_clear` (sampled on `bkp_clk`) clears it. Clearing the flag does not change the clock source.
- R6: Once a failure is declared, the clock source stays on the backup clock even after `ext_clk` transitions return. Only `rst_n` selects the external clock again.
- R7: With `mon_disable` at 1 and no failure declared, a stopped `ext_clk` causes no failure, `clk_out` follows the external source, and `bkp_osc_en` is 0.
- R8: Raising `mon_disable` after a failure leaves `use_backup` at 1 and `bkp_osc_en` at 1.
- R9: After reset with `mon_disable` at 0, monitoring is on: `bkp_osc_en` is 1, `use_backup` is 0 and `irq_flag` is 0.
- R10: The backup clock gate is never open while the external clock gate is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bkp_clk | input | 1 | Free-running backup clock; clocks the monitor |
| ext_clk | input | 1 | External oscillator input under watch |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mode_strap | input | 3 | Clock mode strap, captured during reset |
| mon_disable | input | 1 | Configuration bit that turns monitoring off |
| irq_clear | input | 1 | Write-one-to-clear for the interrupt flag, in the `bkp_clk` domain |
| clk_out | output | 1 | Selected system clock |
| use_backup | output | 1 | 1 when the backup clock drives `clk_out` |
| irq_flag | output | 1 | Sticky oscillator-failure interrupt request |
| bkp_osc_en | output | 1 | Enable for the backup oscillator |
| clk_mode | output | 2 | Decoded strap mode: 0 multiplier reference, 1 halved, 2 direct |

## Verification
The main pattern is a square wave on `ext_clk` whose half-period is swept over every value from 2 to 20 backup cycles, with a reset before each step. This sweep pins the failure threshold to the exact cycle: 16 must pass and 17 must trip. A second pattern stops the oscillator outright and then restarts it. This shows the difference between a late detection and a missing one, and shows that the switchover holds when the oscillator recovers. Edge counts on `clk_out` over a fixed window tell the halved, direct and backup sources apart. All eight strap codes are applied through reset, and each is then overwritten after release to show that the captured value holds.

// File: rtl/osc_fo_pkg.sv
`timescale 1ns/1ps
package osc_fo_pkg;
  typedef enum logic [1:0] {
    CLKM_MULT   = 2'd0,
    CLKM_HALF   = 2'd1,
    CLKM_DIRECT = 2'd2
  } clk_mode_e;

  localparam logic [2:0] STRAP_HALF   = 3'b001;
  localparam logic [2:0] STRAP_DIRECT = 3'b011;

  function automatic clk_mode_e decode_strap(input logic [2:0] code);
    case (code)
      STRAP_HALF:   return CLKM_HALF;
      STRAP_DIRECT: return CLKM_DIRECT;
      default:      return CLKM_MULT;
    endcase
  endfunction
endpackage

// File: rtl/osc_fo_detect.sv
`timescale 1ns/1ps
module osc_fo_detect #(
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  input  logic active,
  input  logic irq_clr,
  output logic fail_o,
  output logic irq_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

  logic [SYNC_STAGES:0] smp_q;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 fail_q, fail_d;
  logic                 irq_q, irq_d;
  logic                 osc_edge, trip;

  // synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= {smp_q[SYNC_STAGES-1:0], osc_in};
  end

  assign osc_edge = smp_q[SYNC_STAGES] ^ smp_q[SYNC_STAGES-1];
  assign trip     = active && !fail_q && !osc_edge && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d  = cnt_q;
    fail_d = fail_q | trip;
    irq_d  = irq_q;
    if (!active || osc_edge || fail_q) cnt_d = '0;
    else if (cnt_q != CNT_LAST)        cnt_d = cnt_q + 1'b1;
    if (irq_clr) irq_d = 1'b0;
    if (trip)    irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fail_q <= fail_d;
      irq_q  <= irq_d;
    end
  end

  assign fail_o = fail_q;
  assign irq_o  = irq_q;

  // R3
  edge_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_edge |=> (cnt_q == '0));
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |=> fail_q);
  // R5
  irq_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> irq_q);
  // R7
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0));
endmodule

// File: rtl/osc_fo_clksel.sv
`timescale 1ns/1ps
module osc_fo_clksel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  bkp_clk,
  input  logic                  ext_clk,
  input  logic                  rst_n,
  input  logic                  rst_b_n,
  input  logic                  fail,
  input  osc_fo_pkg::clk_mode_e mode,
  output logic                  clk_out,
  output logic                  use_bkp
);
  import osc_fo_pkg::*;

  logic                   half_q;
  logic                   src_clk;
  logic                   ext_en_q;
  logic [SYNC_STAGES-1:0] ext_en_s_q;
  logic                   bkp_en_q, bkp_en_d;

  // divide-by-two of the external clock
  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign src_clk = (mode == CLKM_HALF) ? half_q : ext_clk;

  // external gate: closed at once on failure, since the source may be dead
  always_ff @(negedge src_clk or negedge rst_n or posedge fail) begin
    if (!rst_n)    ext_en_q <= 1'b1;
    else if (fail) ext_en_q <= 1'b0;
    else           ext_en_q <= 1'b1;
  end

  // bring the external gate state into the backup domain
  always_ff @(posedge bkp_clk or negedge rst_b_n) begin
    if (!rst_b_n) ext_en_s_q <= '1;
    else          ext_en_s_q <= {ext_en_s_q[SYNC_STAGES-2:0], ext_en_q};
  end

  assign bkp_en_d = fail && !ext_en_s_q[SYNC_STAGES-1];

  always_ff @(negedge bkp_clk or negedge rst_b_n) begin
    if (!rst_b_n) bkp_en_q <= 1'b0;
    else          bkp_en_q <= bkp_en_d;
  end

  assign clk_out = (src_clk & ext_en_q) | (bkp_clk & bkp_en_q);
  assign use_bkp = bkp_en_q;

  // R10
  gate_excl_chk: assert property (@(posedge bkp_clk) disable iff (!rst_b_n)
    bkp_en_q |-> !ext_en_q);
endmodule

// File: rtl/osc_failover_top.sv
`timescale 1ns/1ps
module osc_failover_top #(
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       bkp_clk,
  input  logic       ext_clk,
  input  logic       rst_n,
  input  logic [2:0] mode_strap,
  input  logic       mon_disable,
  input  logic       irq_clear,
  output logic       clk_out,
  output logic       use_backup,
  output logic       irq_flag,
  output logic       bkp_osc_en,
  output logic [1:0] clk_mode
);
  import osc_fo_pkg::*;

  logic [1:0] rst_s_q;
  logic       rst_b_n;
  clk_mode_e  mode_q;
  logic       fail;

  // reset asserts asynchronously, releases on bkp_clk
  always_ff @(posedge bkp_clk or negedge rst_n) begin
    if (!rst_n) rst_s_q <= 2'b00;
    else        rst_s_q <= {rst_s_q[0], 1'b1};
  end
  assign rst_b_n = rst_s_q[1];

  // strap capture while reset is held
  always_ff @(posedge bkp_clk) begin
    if (!rst_b_n) mode_q <= decode_strap(mode_strap);
  end

  osc_fo_detect #(.TIMEOUT(TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) det_i (
    .clk     (bkp_clk),
    .rst_n   (rst_b_n),
    .osc_in  (ext_clk),
    .active  (!mon_disable),
    .irq_clr (irq_clear),
    .fail_o  (fail),
    .irq_o   (irq_flag)
  );

  osc_fo_clksel #(.SYNC_STAGES(SYNC_STAGES)) sel_i (
    .bkp_clk (bkp_clk),
    .ext_clk (ext_clk),
    .rst_n   (rst_n),
    .rst_b_n (rst_b_n),
    .fail    (fail),
    .mode    (mode_q),
    .clk_out (clk_out),
    .use_bkp (use_backup)
  );

  assign bkp_osc_en = !mon_disable || fail;
  assign clk_mode   = mode_q;
endmodule

// File: tb/osc_failover_top_tb_top.sv
`timescale 1ns/1ps
module osc_failover_top_tb_top;
  logic       bkp_clk = 1'b0;
  logic       ext_clk;
  logic       rst_n;
  logic [2:0] mode_strap;
  logic       mon_disable;
  logic       irq_clear;
  logic       clk_out, use_backup, irq_flag, bkp_osc_en;
  logic [1:0] clk_mode;

  int  checks = 0;
  int  failures = 0;
  int  ext_half = 4;
  bit  ext_run = 1'b1;
  bit  cnt_en = 1'b0;
  int  n_out = 0;
  int  n_ext = 0;

  always #2.5 bkp_clk = ~bkp_clk;

  osc_failover_top dut_i (
    .bkp_clk(bkp_clk), .ext_clk(ext_clk), .rst_n(rst_n),
    .mode_strap(mode_strap), .mon_disable(mon_disable), .irq_clear(irq_clear),
    .clk_out(clk_out), .use_backup(use_backup), .irq_flag(irq_flag),
    .bkp_osc_en(bkp_osc_en), .clk_mode(clk_mode)
  );

  // external oscillator model: toggles every ext_half backup cycles
  initial begin
    ext_clk = 1'b0;
    forever begin
      if (ext_run) begin
        repeat (ext_half) @(negedge bkp_clk);
        if (ext_run) ext_clk = ~ext_clk;
      end else begin
        @(negedge bkp_clk);
      end
    end
  end

  always @(posedge clk_out) if (cnt_en) n_out++;
  always @(posedge ext_clk) if (cnt_en) n_ext++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input int act, input int exp);
    checks++;
    if (act < exp - 1 || act > exp + 1) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] strap);
    @(negedge bkp_clk);
    rst_n = 1'b0;
    mode_strap = strap;
    repeat (4) @(negedge bkp_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge bkp_clk);
  endtask

  task automatic count_window(input int cycles);
    @(negedge bkp_clk);
    n_out = 0; n_ext = 0; cnt_en = 1'b1;
    repeat (cycles) @(negedge bkp_clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; mode_strap = 3'b011; mon_disable = 1'b0; irq_clear = 1'b0;

    // R9: reset state
    do_reset(3'b011);
    chk("R9 bkp_osc_en", int'(bkp_osc_en), 1);
    chk("R9 use_backup", int'(use_backup), 0);
    chk("R9 irq_flag", int'(irq_flag), 0);

    // R1: every strap code, then overwrite after release
    for (int c = 0; c < 8; c++) begin
      int exp_m;
      exp_m = (c == 1) ? 1 : (c == 3) ? 2 : 0;
      do_reset(3'(c));
      mode_strap = ~3'(c);
      repeat (3) @(negedge bkp_clk);
      chk("R1 strap decode", int'(clk_mode), exp_m);
    end

    // R2: halved versus direct edge counts (ext period 8 cycles)
    ext_half = 4;
    do_reset(3'b001);
    count_window(160);
    chk_near("R2 ext edges", n_ext, 20);
    chk_near("R2 halved clk_out edges", n_out, 10);
    do_reset(3'b011);
    count_window(160);
    chk_near("R2 direct clk_out edges", n_out, 20);

    // R3/R4: sweep of half-periods, threshold at 17
    for (int h = 2; h <= 20; h++) begin
      ext_half = h;
      do_reset(3'b011);
      repeat (120) @(negedge bkp_clk);
      chk((h >= 17) ? "R4 sweep use_backup" : "R3 sweep use_backup",
          int'(use_backup), (h >= 17) ? 1 : 0);
      chk("R5 sweep irq_flag", int'(irq_flag), (h >= 17) ? 1 : 0);
    end

    // R4: stopped oscillator
    ext_half = 4;
    do_reset(3'b011);
    repeat (50) @(negedge bkp_clk);
    ext_run = 1'b0;
    repeat (10) @(negedge bkp_clk);
    chk("R4 no early detection", int'(use_backup), 0);
    repeat (30) @(negedge bkp_clk);
    chk("R4 switched after stop", int'(use_backup), 1);
    chk("R5 irq after stop", int'(irq_flag), 1);

    // R6: oscillator returns, stays on backup
    ext_run = 1'b1;
    repeat (100) @(negedge bkp_clk);
    chk("R6 sticky use_backup", int'(use_backup), 1);
    count_window(160);
    chk_near("R4 clk_out at backup rate", n_out, 160);

    // R5: clear the flag
    irq_clear = 1'b1;
    @(negedge bkp_clk);
    irq_clear = 1'b0;
    repeat (3) @(negedge bkp_clk);
    chk("R5 irq cleared", int'(irq_flag), 0);
    chk("R5 clear keeps source", int'(use_backup), 1);

    // R8: disable after failure
    mon_disable = 1'b1;
    repeat (20) @(negedge bkp_clk);
    chk("R8 use_backup held", int'(use_backup), 1);
    chk("R8 bkp_osc_en held", int'(bkp_osc_en), 1);

    // R6/R7: reset with monitoring disabled
    do_reset(3'b011);
    chk("R6 reset restores external", int'(use_backup), 0);
    chk("R7 bkp_osc_en off", int'(bkp_osc_en), 0);
    ext_run = 1'b0;
    repeat (100) @(negedge bkp_clk);
    chk("R7 no detection", int'(use_backup), 0);
    chk("R7 no irq", int'(irq_flag), 0);
    count_window(40);
    chk("R7 clk_out follows stopped source", n_out, 0);

    // R9: enabling monitoring again detects the stopped oscillator
    mon_disable = 1'b0;
    repeat (40) @(negedge bkp_clk);
    chk("R9 monitoring re-enabled", int'(use_backup), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #750000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule